// File: doc/BRIEF.md
# Error Event Interrupt Aggregator

This block gathers error indications from a parameterised number of event groups, each 32 events wide, and condenses them into one high-priority interrupt. The interrupt appears at two pins: a level that stays high while any qualifying event is pending, and a one-cycle pulse. An event qualifies when software has enabled it, mapped it to high priority, and its raw status bit is set. Raw status is set by a rising edge on the event input or by a software write. Software clears it by writing ones to the group's enabled-status/clear register.

Software learns which event to service from a prioritized readout. The readout gives the smallest pending global event number, which is the group index times 32 plus the bit index. Pulse-type events and level-type events are reported separately. The lowest `PULSE_GROUPS` groups hold pulse-type events and the remaining groups hold level-type events. A group summary register shows which groups have pending events.

After service, software writes the end-of-interrupt register. The pulse output then fires again if qualifying events remain. A small error-pin controller latches whenever a newly set event that is allowed to influence the pin appears. Writing the clear command to the pin control register releases it.

The register port is a plain strobe (`reg_valid` with `reg_write`) with a combinational read path. It has no back-pressure: every strobed write takes effect at the next clock edge.

Top module: `err_irq_agg`

## Requirements
- R1: Event i is pending exactly when its enable bit, its high-priority map bit and its raw status bit are all 1. `irq_level` is high whenever at least one event is pending.
- R2: The readout at word address 0x40 has two fields. Bits 31:16 hold the smallest pending global number (group*32+bit) among the pulse-type groups, which are groups 0 to PULSE_GROUPS-1. Bits 15:0 hold the smallest pending number among the remaining, level-type, groups.
- R3: A field of the readout is 0xFFFF when no event of its kind is pending. Both fields are 0xFFFF whenever `irq_level` is low, including after reset.
- R4: Bit g of the group summary register at 0x41 is 1 exactly when group g has a pending event.
- R5: Writing to group offset 5 clears raw status for each 1 bit written, and 0 bits have no effect. Reading offset 5 returns raw status ANDed with enable.
- R6: `irq_pulse` is high for one cycle in the cycle after events become pending while no pulse is outstanding. After that, no further pulse occurs until the end-of-interrupt register (0x42) is written. The write gives one pulse in the following cycle if events are still pending, and no pulse otherwise.
- R7: Enable (offsets 0 set, 1 clear), priority map (offsets 2 set, 3 clear) and pin influence (offsets 6 set, 7 clear) change only the bits written as 1. Any of the pair reads the current mask.
- R8: `err_pin` goes high in the cycle after a raw bit whose influence bit is 1 changes from 0 to 1. Writing 0x5 to 0x43 drives it low, repeating the clear has no further effect, and other written values are ignored.
- R9: A rising edge on an event input sets its raw bit. An input held high does not set the bit again after it is cleared. A clear in the same cycle as a new edge leaves the bit set.
- R10: Writing to group offset 4 sets raw status for each 1 bit written, and reading offset 4 returns raw status. Group g registers sit at word address g*8 + offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_GROUPS*32 | Error event inputs, rising edge sets raw status |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Access is a write when high |
| reg_addr | input | 7 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_level | output | 1 | High-priority level interrupt |
| irq_pulse | output | 1 | High-priority one-cycle interrupt pulse |
| err_pin | output | 1 | Latched error pin state |

## Verification
Assertions watch the rules that hold on every cycle. These are that a clear without a competing set leaves the bit clear, that an input edge always lands in raw status, and that masks stay still when no set/clear write occurs. They also check that the pulse never lasts two cycles, that an idle interrupt reads as all-ones, and that a pin clear with no new event drops the pin. Only the bench scenarios can show the behaviours that depend on ordering and values. These include the priority order across groups and event kinds, the pulse reappearing only after end-of-interrupt, and an edge winning over a simultaneous clear.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;
  localparam int GRP_W = 32;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;
  localparam int NUM_W = 16;

  typedef enum logic [2:0] {
    OFF_EN_SET   = 3'd0,
    OFF_EN_CLR   = 3'd1,
    OFF_HI_SET   = 3'd2,
    OFF_HI_CLR   = 3'd3,
    OFF_RAW_SET  = 3'd4,
    OFF_STS_CLR  = 3'd5,
    OFF_INF_SET  = 3'd6,
    OFF_INF_CLR  = 3'd7
  } grp_off_e;

  localparam logic [ADDR_W-1:0] A_PRIO = 7'h40;
  localparam logic [ADDR_W-1:0] A_GSTS = 7'h41;
  localparam logic [ADDR_W-1:0] A_EOI  = 7'h42;
  localparam logic [ADDR_W-1:0] A_PIN  = 7'h43;
  localparam logic [DATA_W-1:0] PIN_CLEAR_CMD = 32'h5;
endpackage

// File: rtl/err_irq_group.sv
module err_irq_group
  import err_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] evt_i,
  input  logic             wr_en,
  input  logic [2:0]       wr_off,
  input  logic [GRP_W-1:0] wr_data,
  output logic [GRP_W-1:0] en_o,
  output logic [GRP_W-1:0] hi_o,
  output logic [GRP_W-1:0] raw_o,
  output logic [GRP_W-1:0] inf_o,
  output logic [GRP_W-1:0] pend_o,
  output logic [GRP_W-1:0] newset_o
);
  logic [GRP_W-1:0] evt_q, en_q, hi_q, raw_q, inf_q;
  logic [GRP_W-1:0] rise, set_v, clr_v, raw_d;

  function automatic logic [GRP_W-1:0] hit(input logic [2:0] k);
    return (wr_en && wr_off == k) ? wr_data : '0;
  endfunction

  assign rise  = evt_i & ~evt_q;
  assign set_v = hit(OFF_RAW_SET);
  assign clr_v = hit(OFF_STS_CLR);
  assign raw_d = (raw_q & ~clr_v) | rise | set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      en_q  <= '0;
      hi_q  <= '0;
      raw_q <= '0;
      inf_q <= '0;
    end else begin
      evt_q <= evt_i;
      en_q  <= (en_q  | hit(OFF_EN_SET))  & ~hit(OFF_EN_CLR);
      hi_q  <= (hi_q  | hit(OFF_HI_SET))  & ~hit(OFF_HI_CLR);
      inf_q <= (inf_q | hit(OFF_INF_SET)) & ~hit(OFF_INF_CLR);
      raw_q <= raw_d;
    end
  end

  assign en_o     = en_q;
  assign hi_o     = hi_q;
  assign raw_o    = raw_q;
  assign inf_o    = inf_q;
  assign pend_o   = raw_q & en_q & hi_q;
  assign newset_o = raw_d & ~raw_q & inf_q;

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_v) |=> ((raw_q & $past(clr_v & ~rise & ~set_v)) == '0));

  p_edge_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((raw_q & $past(rise)) == $past(rise)));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(en_q) && $stable(hi_q) && $stable(inf_q)));
endmodule

// File: rtl/err_irq_prio.sv
module err_irq_prio
  import err_irq_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int BASE  = 0
) (
  input  logic [WIDTH-1:0] pend_i,
  output logic [NUM_W-1:0] num_o
);
  always_comb begin
    num_o = '1;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (pend_i[i]) num_o = NUM_W'(BASE + i);
    end
  end
endmodule

// File: rtl/err_irq_agg.sv
module err_irq_agg
  import err_irq_pkg::*;
#(
  parameter int NUM_GROUPS   = 2,
  parameter int PULSE_GROUPS = 1,
  localparam int NUM_EVT     = NUM_GROUPS * GRP_W,
  localparam int PULSE_EVT   = PULSE_GROUPS * GRP_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EVT-1:0]   evt_i,
  input  logic                 reg_valid,
  input  logic                 reg_write,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_level,
  output logic                 irq_pulse,
  output logic                 err_pin
);
  logic [GRP_W-1:0] en_a [NUM_GROUPS];
  logic [GRP_W-1:0] hi_a [NUM_GROUPS];
  logic [GRP_W-1:0] raw_a [NUM_GROUPS];
  logic [GRP_W-1:0] inf_a [NUM_GROUPS];
  logic [GRP_W-1:0] pend_a [NUM_GROUPS];
  logic [GRP_W-1:0] new_a [NUM_GROUPS];
  logic [NUM_EVT-1:0]    all_pend;
  logic [NUM_GROUPS-1:0] grp_sts;
  logic [NUM_W-1:0]      num_pulse, num_level;
  logic [DATA_W-1:0]     prio_word;
  logic wr, eoi_wr, pin_clr, any_new;
  logic busy_q, pulse_q, pin_q;

  assign wr      = reg_valid && reg_write;
  assign eoi_wr  = wr && reg_addr == A_EOI;
  assign pin_clr = wr && reg_addr == A_PIN && reg_wdata == PIN_CLEAR_CMD;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    err_irq_group u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i[g*GRP_W +: GRP_W]),
      .wr_en    (wr && !reg_addr[ADDR_W-1] && reg_addr[5:3] == 3'(g)),
      .wr_off   (reg_addr[2:0]),
      .wr_data  (reg_wdata),
      .en_o     (en_a[g]),
      .hi_o     (hi_a[g]),
      .raw_o    (raw_a[g]),
      .inf_o    (inf_a[g]),
      .pend_o   (pend_a[g]),
      .newset_o (new_a[g])
    );
    assign all_pend[g*GRP_W +: GRP_W] = pend_a[g];
    assign grp_sts[g] = |pend_a[g];
  end

  err_irq_prio #(.WIDTH(PULSE_EVT), .BASE(0)) u_prio_pulse (
    .pend_i (all_pend[PULSE_EVT-1:0]),
    .num_o  (num_pulse)
  );

  err_irq_prio #(.WIDTH(NUM_EVT - PULSE_EVT), .BASE(PULSE_EVT)) u_prio_level (
    .pend_i (all_pend[NUM_EVT-1:PULSE_EVT]),
    .num_o  (num_level)
  );

  assign prio_word = {num_pulse, num_level};
  assign irq_level = |all_pend;

  always_comb begin
    any_new = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) any_new = any_new | (|new_a[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      pulse_q <= irq_level && !busy_q && !eoi_wr;
      if (eoi_wr) busy_q <= 1'b0;
      else if (irq_level) busy_q <= 1'b1;
      if (any_new) pin_q <= 1'b1;
      else if (pin_clr) pin_q <= 1'b0;
    end
  end

  assign irq_pulse = pulse_q;
  assign err_pin   = pin_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[ADDR_W-1]) begin
      unique case (reg_addr)
        A_PRIO:  reg_rdata = prio_word;
        A_GSTS:  reg_rdata = DATA_W'(grp_sts);
        A_PIN:   reg_rdata = DATA_W'(pin_q);
        default: reg_rdata = '0;
      endcase
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (reg_addr[5:3] == 3'(g)) begin
          unique case (reg_addr[2:0])
            OFF_EN_SET, OFF_EN_CLR:   reg_rdata = en_a[g];
            OFF_HI_SET, OFF_HI_CLR:   reg_rdata = hi_a[g];
            OFF_RAW_SET:              reg_rdata = raw_a[g];
            OFF_STS_CLR:              reg_rdata = raw_a[g] & en_a[g];
            default:                  reg_rdata = inf_a[g];
          endcase
        end
      end
    end
  end

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  p_idle_all_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_level |-> (prio_word == '1));

  p_pin_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_clr && !any_new) |=> !err_pin);
endmodule

// File: tb/err_irq_agg_tb.sv
module err_irq_agg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 2;
  localparam int NE = NG * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NE-1:0] evt_i = '0;
  logic reg_valid = 1'b0;
  logic reg_write = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_level, irq_pulse, err_pin;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_irq_agg #(.NUM_GROUPS(NG), .PULSE_GROUPS(1)) u_dut (
    .clk, .rst_n, .evt_i, .reg_valid, .reg_write, .reg_addr,
    .reg_wdata, .reg_rdata, .irq_level, .irq_pulse, .err_pin
  );

  // {raw group1, raw group0, expected readout}
  localparam logic [95:0] TBL [6] = '{
    {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'h0000_0000, 32'h0000_0020, 32'h0005_FFFF},
    {32'h0000_0020, 32'h0000_0000, 32'hFFFF_0025},
    {32'h8000_0100, 32'h0000_0208, 32'h0003_0028},
    {32'h0000_0001, 32'h8000_0000, 32'h001F_0020},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0020}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (irq_pulse) cnt++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R3 reset irq_level", 32'(irq_level), 0);
    check("R6 reset irq_pulse", 32'(irq_pulse), 0);
    check("R8 reset err_pin", 32'(err_pin), 0);
    reg_rd(7'h40, rd); check("R3 reset readout", rd, 32'hFFFF_FFFF);
    reg_rd(7'h41, rd); check("R4 reset group status", rd, 0);

    // R10 software set, R1 three conditions
    reg_wr(7'h04, 32'h4);
    reg_rd(7'h04, rd); check("R10 raw set", rd, 32'h4);
    check("R1 raw only no level", 32'(irq_level), 0);
    reg_wr(7'h00, 32'h4);
    check("R1 raw+en no level", 32'(irq_level), 0);
    reg_wr(7'h02, 32'h4);
    check("R1 all three level", 32'(irq_level), 1);
    check("R6 pulse not yet", 32'(irq_pulse), 0);
    @(negedge clk);
    check("R6 first pulse", 32'(irq_pulse), 1);
    @(negedge clk);
    check("R6 pulse one cycle", 32'(irq_pulse), 0);
    reg_rd(7'h40, rd); check("R2 readout bit2", rd, 32'h0002_FFFF);
    reg_rd(7'h41, rd); check("R4 group0 pending", rd, 32'h1);

    // R5 enabled-status and clear
    reg_wr(7'h04, 32'h10);
    reg_rd(7'h05, rd); check("R5 status raw&en", rd, 32'h4);
    reg_wr(7'h05, 32'h4);
    reg_rd(7'h04, rd); check("R5 clear only written bit", rd, 32'h10);
    check("R5 level dropped", 32'(irq_level), 0);

    // R6 no pulse while outstanding, then EOI
    reg_wr(7'h04, 32'h4);
    count_pulses(4, cnt); check("R6 no pulse before EOI", cnt, 0);
    reg_wr(7'h42, 32'h0);
    count_pulses(3, cnt); check("R6 EOI repulse", cnt, 1);
    reg_wr(7'h05, 32'h14);
    reg_wr(7'h42, 32'h0);
    count_pulses(3, cnt); check("R6 EOI idle no pulse", cnt, 0);

    // R7 set/clear pairs
    reg_wr(7'h00, 32'h0);
    reg_rd(7'h00, rd); check("R7 zero set no effect", rd, 32'h4);
    reg_wr(7'h00, 32'h0000_0300);
    reg_wr(7'h01, 32'h0000_0104);
    reg_rd(7'h01, rd); check("R7 en clear", rd, 32'h200);
    reg_wr(7'h03, 32'h0);
    reg_rd(7'h02, rd); check("R7 zero clear no effect", rd, 32'h4);
    reg_wr(7'h01, 32'h200);
    reg_wr(7'h00, 32'h4);

    // R8 error pin
    reg_wr(7'h06, 32'h4);
    reg_rd(7'h07, rd); check("R7 influence mask", rd, 32'h4);
    reg_wr(7'h04, 32'h4);
    check("R8 pin set", 32'(err_pin), 1);
    reg_wr(7'h43, 32'h3);
    check("R8 other value ignored", 32'(err_pin), 1);
    reg_wr(7'h43, 32'h5);
    check("R8 clear", 32'(err_pin), 0);
    reg_wr(7'h43, 32'h5);
    check("R8 repeated clear", 32'(err_pin), 0);
    reg_wr(7'h05, 32'h4);

    // R9 event edges
    @(negedge clk); evt_i[7] = 1'b1;
    @(negedge clk);
    reg_rd(7'h04, rd); check("R9 edge sets", rd & 32'h80, 32'h80);
    reg_wr(7'h05, 32'h80);
    @(negedge clk);
    reg_rd(7'h04, rd); check("R9 held high no reset", rd & 32'h80, 0);
    evt_i[7] = 1'b0;
    @(negedge clk);
    evt_i[7] = 1'b1;
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 7'h05; reg_wdata = 32'h80;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    reg_rd(7'h04, rd); check("R9 edge beats clear", rd & 32'h80, 32'h80);

    // R2 table walk
    for (int g = 0; g < NG; g++) begin
      reg_wr(7'(g*8 + 0), 32'hFFFF_FFFF);
      reg_wr(7'(g*8 + 2), 32'hFFFF_FFFF);
    end
    for (int k = 0; k < 6; k++) begin
      reg_wr(7'h05, 32'hFFFF_FFFF);
      reg_wr(7'h0D, 32'hFFFF_FFFF);
      reg_wr(7'h04, TBL[k][63:32]);
      reg_wr(7'h0C, TBL[k][95:64]);
      reg_rd(7'h40, rd); check("R2 readout table", rd, TBL[k][31:0]);
      check("R1 level table", 32'(irq_level), 32'(TBL[k][95:32] != '0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule